// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the combinational hazard logic for an in-order, single-issue, five-stage pipeline. The stages are fetch, decode, execute, memory and writeback. A pipelined multiply path runs beside the execute stage and writes back through the same single register-file write port. Each cycle the block reads the register fields of the instructions held in the pipeline latches: source and destination numbers, a write-enable that marks a valid destination, and an operation class. From these it produces four outputs:

- a forwarding select for each ALU operand;
- a forwarding select for the store-data input of data memory;
- one stall line.

While stall is high, the surrounding pipeline holds the PC and the decode latch and loads a bubble into the execute latch. The block raises stall again each cycle for as long as the hazard remains. A branch flush input turns the decode and execute contents into bubbles, so it overrides the stall.

The stall combines four hazard checks:

- a load followed directly by a consumer of its result;
- a decode operand that waits for a multiply still in flight;
- two writebacks that would collide on the single write port;
- a younger write that an older, slower multiply would overwrite.

Top module: `hz_ctrl`

## Requirements
- R1: Each ALU operand select `fwd_a` (source `x_rs1`) and `fwd_b` (source `x_rs2`) is 1 when the source matches the memory-stage destination, else 2 when it matches the writeback-stage destination, else 0 (register file). The value 3 never appears.
- R2: When an operand source matches both the memory-stage and the writeback-stage destination, the select is 1.
- R3: Register 0 and any destination whose write-enable is low never match a source, for forwarding or for any stall.
- R4: `fwd_st` is 1 only when the memory-stage instruction is a store (class 2) and its data source `m_rs2` matches the writeback-stage destination. Otherwise it is 0.
- R5: A valid decode instruction stalls when the execute-stage instruction is a load (class 1) whose destination equals `d_rs1`, or equals `d_rs2` when the decode instruction is not a store.
- R6: A store in decode whose only match against an execute-stage load is its data source `d_rs2` does not stall.
- R7: A valid decode instruction stalls when either of its sources matches a valid destination in multiply stages 0 to MUL_DEPTH-2.
- R8: A valid decode instruction that writes a register and is not a multiply (class 3) stalls when multiply stage MUL_DEPTH-3 holds a valid destination.
- R9: A valid, writing, non-multiply decode instruction stalls when its destination equals a valid destination in a multiply stage earlier than MUL_DEPTH-3.
- R10: While `flush` is high, `stall` is 0.
- R11: With `d_valid` low, `stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_valid | input | 1 | Decode latch holds a real instruction |
| d_op | input | 3 | Decode operation class (0 ALU, 1 load, 2 store, 3 multiply, 4 branch) |
| d_rs1 | input | REG_W | Decode first source |
| d_rs2 | input | REG_W | Decode second source |
| d_rd | input | REG_W | Decode destination |
| d_we | input | 1 | Decode destination is valid |
| x_op | input | 3 | Execute operation class |
| x_rs1 | input | REG_W | Execute first source |
| x_rs2 | input | REG_W | Execute second source |
| x_rd | input | REG_W | Execute destination |
| x_we | input | 1 | Execute destination is valid |
| m_op | input | 3 | Memory-stage operation class |
| m_rs2 | input | REG_W | Memory-stage store-data source |
| m_rd | input | REG_W | Memory-stage destination |
| m_we | input | 1 | Memory-stage destination is valid |
| w_rd | input | REG_W | Writeback-stage destination |
| w_we | input | 1 | Writeback-stage destination is valid |
| mul_rd | input | (MUL_DEPTH-1)*REG_W | Destinations of multiply stages 0 to MUL_DEPTH-2 |
| mul_we | input | MUL_DEPTH-1 | Valid flags of those multiply destinations |
| flush | input | 1 | Branch flush; overrides stall |
| stall | output | 1 | Hold PC and decode latch, inject bubble into execute |
| fwd_a | output | 2 | Select for ALU operand A |
| fwd_b | output | 2 | Select for ALU operand B |
| fwd_st | output | 1 | Take store data from the writeback stage |

## Verification
The assertions assume that the latch fields are coherent snapshots of one pipeline state. A latch with a low write-enable may carry any destination number. Operation classes stay within the five defined codes, and multiply destinations appear only in the multiply stage fields. The stimulus drives every field at once on the falling clock edge. Its random phase draws register numbers from a small range, including register 0, so that matches are frequent, and draws operation classes only from the defined codes.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [2:0] {
    OPC_ALU    = 3'd0,
    OPC_LOAD   = 3'd1,
    OPC_STORE  = 3'd2,
    OPC_MUL    = 3'd3,
    OPC_BRANCH = 3'd4
  } opc_e;

  localparam logic [1:0] SEL_RF  = 2'd0;
  localparam logic [1:0] SEL_MEM = 2'd1;
  localparam logic [1:0] SEL_WB  = 2'd2;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel #(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] m_rd,
  input  logic             m_we,
  input  logic [REG_W-1:0] w_rd,
  input  logic             w_we,
  output logic [1:0]       sel
);
  import hz_pkg::*;

  function automatic logic hit(input logic [REG_W-1:0] s,
                               input logic [REG_W-1:0] d,
                               input logic v);
    return v && (d != '0) && (s == d);
  endfunction

  logic mem_hit, wb_hit;
  assign mem_hit = hit(src, m_rd, m_we);
  assign wb_hit  = hit(src, w_rd, w_we);

  // Younger producer (memory stage) has priority
  always_comb begin
    if (mem_hit)     sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit #(
  parameter int REG_W     = 5,
  parameter int MUL_DEPTH = 4
) (
  input  logic                              d_valid,
  input  logic [2:0]                        d_op,
  input  logic [REG_W-1:0]                  d_rs1,
  input  logic [REG_W-1:0]                  d_rs2,
  input  logic [REG_W-1:0]                  d_rd,
  input  logic                              d_we,
  input  logic [2:0]                        x_op,
  input  logic [REG_W-1:0]                  x_rd,
  input  logic                              x_we,
  input  logic [MUL_DEPTH-2:0][REG_W-1:0]   mul_rd,
  input  logic [MUL_DEPTH-2:0]              mul_we,
  output logic                              ld_use,
  output logic                              mul_src,
  output logic                              wport,
  output logic                              worder
);
  import hz_pkg::*;

  localparam int NSRC    = MUL_DEPTH - 1;   // stages whose result is not yet forwardable
  localparam int COLLIDE = MUL_DEPTH - 3;   // stage that reaches writeback with a decode insn
  localparam int NORDER  = MUL_DEPTH - 3;   // stages that would finish after a decode insn

  function automatic logic hit(input logic [REG_W-1:0] s,
                               input logic [REG_W-1:0] d,
                               input logic v);
    return v && (d != '0) && (s == d);
  endfunction

  logic d_is_store, d_is_mul, d_writes;
  assign d_is_store = (d_op == OPC_STORE);
  assign d_is_mul   = (d_op == OPC_MUL);
  assign d_writes   = d_valid && d_we && (d_rd != '0) && !d_is_mul;

  // load followed by a dependent consumer
  logic x_is_load;
  assign x_is_load = (x_op == OPC_LOAD);
  assign ld_use = d_valid && x_is_load &&
                  (hit(d_rs1, x_rd, x_we) ||
                   (!d_is_store && hit(d_rs2, x_rd, x_we)));

  // sources waiting for an in-flight multiply
  logic [NSRC-1:0] src_hit;
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    assign src_hit[k] = hit(d_rs1, mul_rd[k], mul_we[k]) ||
                        hit(d_rs2, mul_rd[k], mul_we[k]);
  end
  assign mul_src = d_valid && (|src_hit);

  // single write port collision
  assign wport = d_writes && mul_we[COLLIDE] && (mul_rd[COLLIDE] != '0);

  // younger write overtaken by an older multiply
  if (NORDER > 0) begin : g_ord
    logic [NORDER-1:0] ord_hit;
    for (genvar k = 0; k < NORDER; k++) begin : g_stage
      assign ord_hit[k] = hit(d_rd, mul_rd[k], mul_we[k]);
    end
    assign worder = d_writes && (|ord_hit);
  end else begin : g_no_ord
    assign worder = 1'b0;
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
  parameter int REG_W     = 5,
  parameter int MUL_DEPTH = 4
) (
  input  logic                             d_valid,
  input  logic [2:0]                       d_op,
  input  logic [REG_W-1:0]                 d_rs1,
  input  logic [REG_W-1:0]                 d_rs2,
  input  logic [REG_W-1:0]                 d_rd,
  input  logic                             d_we,
  input  logic [2:0]                       x_op,
  input  logic [REG_W-1:0]                 x_rs1,
  input  logic [REG_W-1:0]                 x_rs2,
  input  logic [REG_W-1:0]                 x_rd,
  input  logic                             x_we,
  input  logic [2:0]                       m_op,
  input  logic [REG_W-1:0]                 m_rs2,
  input  logic [REG_W-1:0]                 m_rd,
  input  logic                             m_we,
  input  logic [REG_W-1:0]                 w_rd,
  input  logic                             w_we,
  input  logic [MUL_DEPTH-2:0][REG_W-1:0]  mul_rd,
  input  logic [MUL_DEPTH-2:0]             mul_we,
  input  logic                             flush,
  output logic                             stall,
  output logic [1:0]                       fwd_a,
  output logic [1:0]                       fwd_b,
  output logic                             fwd_st
);
  import hz_pkg::*;

  localparam int NOPND = 2;

  // operand forwarding, one selector per ALU input
  logic [NOPND-1:0][REG_W-1:0] opnd_src;
  logic [NOPND-1:0][1:0]       opnd_sel;
  assign opnd_src[0] = x_rs1;
  assign opnd_src[1] = x_rs2;

  for (genvar i = 0; i < NOPND; i++) begin : g_opnd
    hz_fwd_sel #(.REG_W(REG_W)) u_sel (
      .src (opnd_src[i]),
      .m_rd(m_rd),
      .m_we(m_we),
      .w_rd(w_rd),
      .w_we(w_we),
      .sel (opnd_sel[i])
    );
  end
  assign fwd_a = opnd_sel[0];
  assign fwd_b = opnd_sel[1];

  // store data may come from writeback; the address never does
  logic m_is_store;
  assign m_is_store = (m_op == OPC_STORE);
  assign fwd_st = m_is_store && w_we && (w_rd != '0) && (m_rs2 == w_rd);

  // hazard conditions, visible as named wires
  logic ld_use, mul_src, wport, worder, hazard;

  hz_stall_unit #(.REG_W(REG_W), .MUL_DEPTH(MUL_DEPTH)) u_stall (
    .d_valid(d_valid),
    .d_op   (d_op),
    .d_rs1  (d_rs1),
    .d_rs2  (d_rs2),
    .d_rd   (d_rd),
    .d_we   (d_we),
    .x_op   (x_op),
    .x_rd   (x_rd),
    .x_we   (x_we),
    .mul_rd (mul_rd),
    .mul_we (mul_we),
    .ld_use (ld_use),
    .mul_src(mul_src),
    .wport  (wport),
    .worder (worder)
  );

  assign hazard = ld_use | mul_src | wport | worder;
  assign stall  = hazard & ~flush;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int REG_W = 5
) (
  input logic             d_valid,
  input logic [2:0]       d_op,
  input logic [REG_W-1:0] d_rs1,
  input logic [REG_W-1:0] x_rs1,
  input logic [REG_W-1:0] x_rd,
  input logic [2:0]       m_op,
  input logic [REG_W-1:0] m_rd,
  input logic             m_we,
  input logic             flush,
  input logic             stall,
  input logic [1:0]       fwd_a,
  input logic [1:0]       fwd_b,
  input logic             fwd_st,
  input logic             ld_use,
  input logic             mul_src,
  input logic             wport,
  input logic             worder
);
  import hz_pkg::*;

  always_comb begin
    // R1
    sel_legal_chk: assert (fwd_a != 2'd3 && fwd_b != 2'd3)
      else $error("operand select out of range");
    // R2
    mem_prio_chk: assert (!(m_we && m_rd != '0 && m_rd == x_rs1) || fwd_a == SEL_MEM)
      else $error("memory-stage match did not win");
    // R3
    zero_src_chk: assert (x_rs1 != '0 || fwd_a == SEL_RF)
      else $error("register 0 forwarded");
    // R4
    st_only_chk: assert (!fwd_st || m_op == OPC_STORE)
      else $error("store forward for a non-store");
    // R5
    ld_use_chk: assert (!ld_use || flush || stall)
      else $error("load-use hazard without stall");
    // R6
    st_data_ld_chk: assert (!(d_op == OPC_STORE && x_rd != d_rs1) || !ld_use)
      else $error("store data source raised load-use");
    // R7
    mul_src_chk: assert (!mul_src || flush || stall)
      else $error("multiply source hazard without stall");
    // R8
    wport_chk: assert (!wport || flush || stall)
      else $error("write port collision without stall");
    // R9
    worder_chk: assert (!worder || flush || stall)
      else $error("write order hazard without stall");
    // R10
    flush_wins_chk: assert (!(flush && stall))
      else $error("stall during flush");
    // R11
    idle_d_chk: assert (d_valid || !stall)
      else $error("stall with empty decode");
  end
endmodule

bind hz_ctrl hz_ctrl_chk #(.REG_W(REG_W)) chk_i (
  .d_valid(d_valid),
  .d_op   (d_op),
  .d_rs1  (d_rs1),
  .x_rs1  (x_rs1),
  .x_rd   (x_rd),
  .m_op   (m_op),
  .m_rd   (m_rd),
  .m_we   (m_we),
  .flush  (flush),
  .stall  (stall),
  .fwd_a  (fwd_a),
  .fwd_b  (fwd_b),
  .fwd_st (fwd_st),
  .ld_use (ld_use),
  .mul_src(mul_src),
  .wport  (wport),
  .worder (worder)
);

// File: tb/hz_ctrl_tb_top.sv
`timescale 1ns/1ps
module hz_ctrl_tb_top;
  localparam int RW = 5;
  localparam int MD = 4;
  localparam int NS = MD - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                d_valid, d_we, x_we, m_we, w_we, flush;
  logic [2:0]          d_op, x_op, m_op;
  logic [RW-1:0]       d_rs1, d_rs2, d_rd, x_rs1, x_rs2, x_rd, m_rs2, m_rd, w_rd;
  logic [NS-1:0][RW-1:0] mul_rd;
  logic [NS-1:0]       mul_we;
  logic                stall, fwd_st;
  logic [1:0]          fwd_a, fwd_b;

  hz_ctrl #(.REG_W(RW), .MUL_DEPTH(MD)) dut_i (
    .d_valid(d_valid), .d_op(d_op), .d_rs1(d_rs1), .d_rs2(d_rs2), .d_rd(d_rd), .d_we(d_we),
    .x_op(x_op), .x_rs1(x_rs1), .x_rs2(x_rs2), .x_rd(x_rd), .x_we(x_we),
    .m_op(m_op), .m_rs2(m_rs2), .m_rd(m_rd), .m_we(m_we),
    .w_rd(w_rd), .w_we(w_we), .mul_rd(mul_rd), .mul_we(mul_we), .flush(flush),
    .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_st(fwd_st)
  );

  typedef struct {
    logic       stall;
    logic [1:0] fa;
    logic [1:0] fb;
    logic       fst;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // independent reference, written from the requirements
  function automatic bit same(input logic [RW-1:0] a, input logic [RW-1:0] b, input logic en);
    if (!en || b == 0) return 0;
    return a == b;
  endfunction

  function automatic logic [1:0] pick(input logic [RW-1:0] s);
    logic [1:0] r = 2'd0;
    if (same(s, w_rd, w_we)) r = 2'd2;
    if (same(s, m_rd, m_we)) r = 2'd1;   // memory stage overrides
    return r;
  endfunction

  function automatic logic model_stall();
    bit h = 0;
    bit wr;
    if (!d_valid || flush) return 0;
    // load-use (load=1, store=2)
    if (x_op == 3'd1 && (same(d_rs1, x_rd, x_we) || (d_op != 3'd2 && same(d_rs2, x_rd, x_we)))) h = 1;
    // multiply stages 0..2 sources
    for (int k = 0; k < NS; k++)
      if (same(d_rs1, mul_rd[k], mul_we[k]) || same(d_rs2, mul_rd[k], mul_we[k])) h = 1;
    wr = d_we && d_rd != 0 && d_op != 3'd3;
    // write port: stage 1 with four multiply stages
    if (wr && mul_we[1] && mul_rd[1] != 0) h = 1;
    // write order: stage 0
    if (wr && same(d_rd, mul_rd[0], mul_we[0])) h = 1;
    return h;
  endfunction

  task automatic idle();
    d_valid = 0; d_op = 0; d_rs1 = 0; d_rs2 = 0; d_rd = 0; d_we = 0;
    x_op = 0; x_rs1 = 0; x_rs2 = 0; x_rd = 0; x_we = 0;
    m_op = 0; m_rs2 = 0; m_rd = 0; m_we = 0; w_rd = 0; w_we = 0;
    mul_rd = '0; mul_we = '0; flush = 0;
  endtask

  // driver: inputs are already set; push the expectation and let the monitor compare
  task automatic push(input string tag);
    exp_t e;
    e.stall = model_stall();
    e.fa    = pick(x_rs1);
    e.fb    = pick(x_rs2);
    e.fst   = (m_op == 3'd2) && same(m_rs2, w_rd, w_we);
    e.tag   = tag;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  // monitor: combinational outputs settled half a cycle after the drive
  always @(posedge clk) begin
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (stall !== e.stall || fwd_a !== e.fa || fwd_b !== e.fb || fwd_st !== e.fst) begin
        n_fail++;
        $display("FAIL %s: got stall=%b fa=%0d fb=%0d fst=%b, expected stall=%b fa=%0d fb=%0d fst=%b",
                 e.tag, stall, fwd_a, fwd_b, fwd_st, e.stall, e.fa, e.fb, e.fst);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no end of stimulus, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    push("R11 reset state, empty pipeline");

    idle(); x_rs1 = 3; m_rd = 3; m_we = 1;                      push("R1 operand A from memory stage");
    idle(); x_rs2 = 4; w_rd = 4; w_we = 1;                      push("R1 operand B from writeback stage");
    idle(); x_rs1 = 5; x_rs2 = 5; m_rd = 5; m_we = 1; w_rd = 5; w_we = 1; push("R2 memory stage wins");
    idle(); x_rs1 = 0; m_rd = 0; m_we = 1;                      push("R3 register 0 not forwarded");
    idle(); x_rs1 = 6; m_rd = 6; m_we = 0;                      push("R3 invalid destination not forwarded");
    idle(); m_op = 3'd2; m_rs2 = 9; w_rd = 9; w_we = 1;         push("R4 store data from writeback");
    idle(); m_op = 3'd0; m_rs2 = 9; w_rd = 9; w_we = 1;         push("R4 non-store gets no store forward");
    idle(); d_valid = 1; d_rs1 = 2; x_op = 3'd1; x_rd = 2; x_we = 1; push("R5 load-use on first source");
    idle(); d_valid = 1; d_rs2 = 2; x_op = 3'd1; x_rd = 2; x_we = 1; push("R5 load-use on second source");
    idle(); d_valid = 1; d_op = 3'd2; d_rs1 = 7; d_rs2 = 2; x_op = 3'd1; x_rd = 2; x_we = 1;
    push("R6 store data source only, no stall");
    idle(); d_valid = 1; d_rs1 = 2; x_op = 3'd0; x_rd = 2; x_we = 1; push("R5 ALU producer forwards, no stall");
    idle(); d_valid = 1; d_rs2 = 8; mul_rd[2] = 8; mul_we[2] = 1; push("R7 source waits for multiply stage 2");
    idle(); d_valid = 1; d_rs1 = 8; mul_rd[0] = 8; mul_we[0] = 1; push("R7 source waits for multiply stage 0");
    idle(); d_valid = 1; d_op = 3'd0; d_rd = 10; d_we = 1; mul_rd[1] = 11; mul_we[1] = 1;
    push("R8 write port collision");
    idle(); d_valid = 1; d_op = 3'd3; d_rd = 10; d_we = 1; mul_rd[1] = 11; mul_we[1] = 1;
    push("R8 multiply in decode does not collide");
    idle(); d_valid = 1; d_op = 3'd0; d_rd = 12; d_we = 1; mul_rd[0] = 12; mul_we[0] = 1;
    push("R9 write order against older multiply");
    idle(); d_valid = 1; d_op = 3'd0; d_rd = 12; d_we = 1; mul_rd[0] = 13; mul_we[0] = 1;
    push("R9 different destination, no stall");
    idle(); d_valid = 1; d_rs1 = 2; x_op = 3'd1; x_rd = 2; x_we = 1; flush = 1;
    push("R10 flush overrides stall");
    idle(); d_valid = 0; d_rs1 = 2; x_op = 3'd1; x_rd = 2; x_we = 1; push("R11 empty decode never stalls");

    for (int n = 0; n < 400; n++) begin
      d_valid = 1'($urandom_range(0, 1)); d_op = 3'($urandom_range(0, 4));
      d_rs1 = RW'($urandom_range(0, 3)); d_rs2 = RW'($urandom_range(0, 3));
      d_rd = RW'($urandom_range(0, 3)); d_we = 1'($urandom_range(0, 1));
      x_op = 3'($urandom_range(0, 4)); x_rs1 = RW'($urandom_range(0, 3));
      x_rs2 = RW'($urandom_range(0, 3)); x_rd = RW'($urandom_range(0, 3));
      x_we = 1'($urandom_range(0, 1)); m_op = 3'($urandom_range(0, 4));
      m_rs2 = RW'($urandom_range(0, 3)); m_rd = RW'($urandom_range(0, 3));
      m_we = 1'($urandom_range(0, 1)); w_rd = RW'($urandom_range(0, 3));
      w_we = 1'($urandom_range(0, 1));
      for (int k = 0; k < NS; k++) begin
        mul_rd[k] = RW'($urandom_range(0, 3));
        mul_we[k] = ($urandom_range(0, 3) == 0);
      end
      flush = ($urandom_range(0, 7) == 0);
      push("random mix R1 R2 R3 R4 R5 R7 R8 R9 R10");
    end

    while (exp_q.size() != 0) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule